// File: doc/BRIEF.md
# Dual-Mode FM0 / Manchester Line Encoder

This block turns a serial bit stream into a self-clocking line code for a short-range vehicular radio baseband. One input picks the code for each bit: FM0 (bi-phase space) or Manchester. Each bit period takes two enabled clock cycles, one for each half-bit. An internal phase toggle marks the halves. The data bit is sampled when the first half starts. The line output is registered, so it carries no glitches.

Both codes share one output register and one phase generator. FM0 keeps its per-bit state in two flip-flops. Manchester is a multiplexer that uses the half-bit phase as its select and the data bit and its complement as its inputs. The registers that belong to only one code load only while that code is active, so the idle code's logic stays still. A mode change takes effect at the next bit boundary. Dropping the enable freezes the line and the phase.

Top module: `dual_line_encoder`

## Requirements
- R1: During and after a synchronous reset, `line_out` is low and `first_half` is low. Each enabled cycle then inverts `first_half`, and a disabled cycle leaves it unchanged.
- R2: In FM0 mode (`mode` = 0), the enabled edge that starts a bit (while `first_half` is low) inverts `line_out`, whatever the data bit.
- R3: In FM0 mode, a data 0 makes the second half of the bit the inverse of its first half.
- R4: In FM0 mode, a data 1 makes the second half of the bit equal to its first half.
- R5: In Manchester mode (`mode` = 1), a data 1 is sent as low in the first half and high in the second half.
- R6: In Manchester mode, a data 0 is sent as high in the first half and low in the second half.
- R7: While `en` is low, `line_out` and `first_half` keep their values, including in the middle of a bit.
- R8: `mode` is sampled only at the edge that starts a bit. A change of `mode` during the first half does not alter that bit's second half.
- R9: `din` is sampled only at the edge that starts a bit. A change of `din` during the first half does not alter that bit's second half.
- R10: The first FM0 bit after reset has a high first half, because the line starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one enabled cycle per half-bit |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the encoder by one half-bit when high |
| mode | input | 1 | Code select: 0 = FM0, 1 = Manchester; sampled at bit start |
| din | input | 1 | Data bit; sampled at bit start |
| first_half | output | 1 | High while `line_out` shows the first half of a bit |
| line_out | output | 1 | Registered encoded line level |

## Verification
The properties assume that `mode` and `din` are stable across each enabled clock edge. They also assume that the environment changes them only at the half-bit where they are meant to take effect, or deliberately in the middle of a bit to probe R8 and R9. The stimulus changes every input on the falling clock edge. It runs FM0 and Manchester bits back to back. It toggles `din` and `mode` between the two halves of some bits and holds `en` low both within bits and between them. For every half-bit, the expected levels come from a small line-level model in the bench.

// File: rtl/enc_pkg.sv
package enc_pkg;
   typedef enum logic {
      ENC_FM0 = 1'b0,
      ENC_MAN = 1'b1
   } enc_mode_e;

   localparam int MAN_STYLE_MUX = 0;
   localparam int MAN_STYLE_XOR = 1;
endpackage

// File: rtl/enc_phase.sv
module enc_phase (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic ph_q,
   output logic bit_start,
   output logic bit_mid
);
   always_ff @(posedge clk) begin
      if (rst)     ph_q <= 1'b0;
      else if (en) ph_q <= ~ph_q;
   end

   assign bit_start = en & ~ph_q;
   assign bit_mid   = en &  ph_q;
endmodule

// File: rtl/enc_fm0_core.sv
module enc_fm0_core (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic din,
   input  logic prev_lvl,
   output logic first_lvl,
   output logic second_lvl
);
   logic fm_first_q;
   logic fm_tog_q;

   // every bit boundary inverts the line
   assign first_lvl = ~prev_lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         fm_first_q <= 1'b0;
         fm_tog_q   <= 1'b0;
      end else if (load) begin
         fm_first_q <= ~prev_lvl;
         fm_tog_q   <= ~din;
      end
   end

   assign second_lvl = fm_first_q ^ fm_tog_q;
endmodule

// File: rtl/enc_man_core.sv
module enc_man_core #(
   parameter int MAN_STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic din,
   input  logic ph,
   output logic lvl
);
   logic man_bit_q;
   logic cur_bit;

   always_ff @(posedge clk) begin
      if (rst)       man_bit_q <= 1'b0;
      else if (load) man_bit_q <= din;
   end

   assign cur_bit = ph ? man_bit_q : din;

   generate
      if (MAN_STYLE == enc_pkg::MAN_STYLE_MUX) begin : g_mux
         always_comb begin
            case (ph)
               1'b0:    lvl = ~cur_bit;
               default: lvl = cur_bit;
            endcase
         end
      end else if (MAN_STYLE == enc_pkg::MAN_STYLE_XOR) begin : g_xor
         assign lvl = cur_bit ^ ~ph;
      end else begin : g_bad
         $error("enc_man_core: MAN_STYLE must be 0 or 1");
         assign lvl = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dual_line_encoder.sv
module dual_line_encoder #(
   parameter bit IDLE_LEVEL = 1'b0,
   parameter int MAN_STYLE  = enc_pkg::MAN_STYLE_MUX
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic mode,
   input  logic din,
   output logic first_half,
   output logic line_out
);
   import enc_pkg::*;

   localparam int N_STYLES = 2;

   generate
      if (MAN_STYLE < 0 || MAN_STYLE >= N_STYLES) begin : g_chk_style
         $error("dual_line_encoder: unsupported MAN_STYLE");
      end
   endgenerate

   logic      ph_q, bit_start, bit_mid;
   enc_mode_e mode_q, act_mode;
   logic      line_q, line_d;
   logic      fm_load, man_load;
   logic      fm_first, fm_second, man_lvl;

   enc_phase u_phase (
      .clk(clk), .rst(rst), .en(en),
      .ph_q(ph_q), .bit_start(bit_start), .bit_mid(bit_mid)
   );

   // mode for the bit in flight: live at the start edge, latched after
   assign act_mode = ph_q ? mode_q : enc_mode_e'(mode);

   always_ff @(posedge clk) begin
      if (rst)            mode_q <= ENC_FM0;
      else if (bit_start) mode_q <= enc_mode_e'(mode);
   end

   assign fm_load  = bit_start & (act_mode == ENC_FM0);
   assign man_load = bit_start & (act_mode == ENC_MAN);

   enc_fm0_core u_fm0 (
      .clk(clk), .rst(rst), .load(fm_load), .din(din),
      .prev_lvl(line_q), .first_lvl(fm_first), .second_lvl(fm_second)
   );

   enc_man_core #(.MAN_STYLE(MAN_STYLE)) u_man (
      .clk(clk), .rst(rst), .load(man_load), .din(din),
      .ph(ph_q), .lvl(man_lvl)
   );

   always_comb begin
      if (act_mode == ENC_MAN) line_d = man_lvl;
      else if (ph_q)           line_d = fm_second;
      else                     line_d = fm_first;
   end

   always_ff @(posedge clk) begin
      if (rst)                     line_q <= IDLE_LEVEL;
      else if (bit_start | bit_mid) line_q <= line_d;
   end

   assign line_out   = line_q;
   assign first_half = ph_q;
endmodule

// File: rtl/enc_checker.sv
module enc_checker (
   input logic clk,
   input logic rst,
   input logic en,
   input logic mode,
   input logic din,
   input logic first_half,
   input logic line_out
);
   logic bit_mode_q;
   logic bit_din_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_mode_q <= 1'b0;
         bit_din_q  <= 1'b0;
      end else if (en && !first_half) begin
         bit_mode_q <= mode;
         bit_din_q  <= din;
      end
   end

   // R1
   phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> (first_half != $past(first_half)));

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(line_out) && $stable(first_half)));

   // R2
   fm0_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !first_half && !mode) |=> (line_out != $past(line_out)));

   // R5 R6
   man_first_half_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !first_half && mode) |=> (line_out == !$past(din)));

   // R3 R4 R8 R9
   fm0_mid_chk: assert property (@(posedge clk) disable iff (rst)
      (en && first_half && !bit_mode_q) |=>
         (line_out == ($past(line_out) ^ !$past(bit_din_q))));

   // R5 R6 R8 R9
   man_second_half_chk: assert property (@(posedge clk) disable iff (rst)
      (en && first_half && bit_mode_q) |=> (line_out == $past(bit_din_q)));
endmodule

bind dual_line_encoder enc_checker i_enc_checker (
   .clk(clk), .rst(rst), .en(en), .mode(mode), .din(din),
   .first_half(first_half), .line_out(line_out)
);

// File: tb/test_dual_line_encoder.sv
`timescale 1ns/1ps
module test_dual_line_encoder;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic mode = 1'b0;
   logic din = 1'b0;
   logic first_half, line_out;

   always #2 clk = ~clk;

   dual_line_encoder i_dual_line_encoder (
      .clk(clk), .rst(rst), .en(en), .mode(mode), .din(din),
      .first_half(first_half), .line_out(line_out)
   );

   typedef struct {
      logic  lvl;
      logic  ph;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   logic model_line = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // driver: one bit; optional mid-bit din flip, mode flip, stall
   task automatic send_bit(input logic m, input logic d, input bit flip_din,
                           input bit flip_mode, input bit stall);
      exp_t e1, e2;
      logic f, s;
      string rq;
      if (m) begin
         f = ~d; s = d;
         rq = d ? "R5" : "R6";
      end else begin
         f = ~model_line; s = d ? f : ~f;
         rq = d ? "R4" : "R3";
      end
      if (flip_din)  rq = {rq, "/R9"};
      if (flip_mode) rq = {rq, "/R8"};
      model_line = s;
      e1.lvl = f; e1.ph = 1'b1; e1.req = m ? rq : "R2";
      e2.lvl = s; e2.ph = 1'b0; e2.req = rq;
      exp_q.push_back(e1);
      exp_q.push_back(e2);
      @(negedge clk);
      mode = m; din = d; en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (flip_din)  din = ~d;
      if (flip_mode) mode = ~m;
      if (stall) begin
         logic hl, hp;
         en = 1'b0;
         hl = line_out; hp = first_half;
         repeat (3) @(negedge clk);
         chk(line_out, hl, "R7", "line mid-bit stall");
         chk(first_half, hp, "R7", "phase mid-bit stall");
         en = 1'b1;
      end
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      logic hl, hp;
      @(negedge clk);
      en = 1'b0;
      din = ~din; mode = ~mode;
      hl = line_out; hp = first_half;
      repeat (n) @(negedge clk);
      chk(line_out, hl, "R7", "line idle");
      chk(first_half, hp, "R7", "phase idle");
   endtask

   // monitor: pops one expected half-bit per enabled edge
   initial begin
      forever begin
         logic en_s, rst_s;
         @(posedge clk);
         en_s = en; rst_s = rst;
         @(negedge clk);
         if (en_s && !rst_s) begin
            if (exp_q.size() == 0) begin
               chk(1'b1, 1'b0, "R1", "unexpected half-bit");
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(line_out, e.lvl, e.req, "line level");
               chk(first_half, e.ph, "R1", "phase");
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(line_out, 1'b0, "R1", "line in reset");
      rst = 1'b0;
      @(negedge clk);
      chk(line_out, 1'b0, "R1", "line after reset");
      chk(first_half, 1'b0, "R1", "phase after reset");
      // R10: first FM0 bit after reset starts high
      send_bit(1'b0, 1'b1, 0, 0, 0);
      send_bit(1'b0, 1'b1, 0, 0, 0);
      send_bit(1'b0, 1'b0, 0, 0, 0);
      send_bit(1'b0, 1'b0, 1, 0, 0);
      send_bit(1'b0, 1'b1, 1, 1, 0);
      send_bit(1'b0, 1'b0, 0, 0, 1);
      idle(4);
      send_bit(1'b1, 1'b1, 0, 0, 0);
      send_bit(1'b1, 1'b0, 0, 0, 0);
      send_bit(1'b1, 1'b0, 1, 0, 0);
      send_bit(1'b1, 1'b1, 1, 1, 1);
      send_bit(1'b1, 1'b1, 0, 0, 0);
      send_bit(1'b0, 1'b0, 0, 1, 0);
      send_bit(1'b0, 1'b1, 0, 0, 0);
      send_bit(1'b1, 1'b0, 0, 0, 0);
      idle(2);
      send_bit(1'b0, 1'b1, 1, 0, 1);
      send_bit(1'b0, 1'b0, 0, 0, 0);
      @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, 1'b1, "R1", "all half-bits produced");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule